// File: doc/BRIEF.md
# Command-Byte Register Access Controller

This block is the byte-level front end of a small sensor register file. It sits behind a serial-bus target that has already done address matching and bit-level signalling. That target hands over each received write byte, marking the first byte of a write transaction. It also raises a one-cycle request whenever the bus wants a byte to send. The controller decides whether a first byte is a command or data. It holds the current register address and access mode, applies writes to an internal bank of configuration registers, and returns read data. It also issues a one-cycle interrupt-clear pulse when a special-function command asks for one.

A command byte has its top bit set. Bits 6:5 choose the access mode: same-address, auto-increment, reserved, or special-function. Bits 4:0 give a register address or a special-function code. Any byte that is not a command writes data at the held address. Reading the low byte of either 16-bit channel result copies that channel's high byte into a shadow. A following read of the high byte then returns a value from the same conversion.

The controller is a five-state machine. Every other state returns to `S_IDLE` after one cycle.

| State | Role |
|---|---|
| `S_IDLE` | Waits for bus events. |
| `S_DECODE` | Interprets a command byte. |
| `S_WRITE` | Performs one data-byte write. |
| `S_READ` | Presents one read byte. |
| `S_CLEAR` | Drives the interrupt-clear pulse. |

| From | Condition | To |
|---|---|---|
| `S_IDLE` | received byte that is a command | `S_DECODE` |
| `S_IDLE` | any other received byte | `S_WRITE` |
| `S_IDLE` | read request, with no byte received in that cycle | `S_READ` |
| `S_DECODE` | the byte is the interrupt-clear special function | `S_CLEAR` |
| `S_DECODE` | any other command | `S_IDLE` |
| `S_WRITE`, `S_READ`, `S_CLEAR` | always | `S_IDLE` |

Bus events must be at least three cycles apart. A serial bus byte takes far longer than that.

Top module: `cmd_reg_access`

## Requirements
- R1: After reset, the integration-time register (0x01) and the wait-time register (0x03) read 0xFF. All other writable registers read 0x00. The held address is 0x00 and the mode is same-address.
- R2: A first byte with bit 7 set is a command. If bits 6:5 are 00, bits 4:0 become the held address, and every later data byte reads or writes that same address.
- R3: If a command's bits 6:5 are 01, bits 4:0 become the held address, and the address advances by one after each data byte read or written. Address 0x1F advances to 0x00.
- R4: Command byte 0xE6 (type 11, code 00110) raises `int_clr` for exactly one cycle, two cycles after the byte is sampled. Other type-11 codes and every type-10 command do nothing, and they leave the held address and mode unchanged.
- R5: A first byte with bit 7 clear is written as data to the held address. A byte that is not first is always data, whatever its bit 7.
- R6: A read request with no new command reads at the held address. `rd_valid` and `rd_data` appear in the cycle after the request is sampled.
- R7: Reading 0x14 or 0x16 copies that channel's bits 15:8 into its shadow. A read of 0x15 or 0x17 returns the shadow, even if the channel input has changed since. Both shadows reset to 0x00.
- R8: Only addresses 0x00, 0x01, 0x03, 0x04-0x07, 0x0C, 0x0D and 0x0F are writable. A write elsewhere gives no `wr_stb` and changes nothing. A read of any address outside the map returns 0x00.
- R9: A data write raises `wr_stb` with `wr_addr` and `wr_data` in the cycle after the byte is sampled. The new value appears on the register output one cycle later.
- R10: Address 0x12 reads the `ID_VALUE` parameter and address 0x13 reads `status_in`. Addresses 0x04/0x05 form the low threshold (low byte, high byte), and 0x06/0x07 form the high threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A written byte is present this cycle |
| rx_first | input | 1 | That byte is the first of its write transaction |
| rx_data | input | 8 | Written byte |
| rd_req | input | 1 | Bus requests a read byte |
| ch0_data | input | 16 | Channel 0 conversion result |
| ch1_data | input | 16 | Channel 1 conversion result |
| status_in | input | 8 | Status byte served at 0x13 |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| wr_stb | output | 1 | Write strobe to a writable register |
| wr_addr | output | 5 | Address of the write |
| wr_data | output | 8 | Data of the write |
| int_clr | output | 1 | One-cycle interrupt-clear pulse |
| en_o | output | 8 | Enable register (0x00) |
| atime_o | output | 8 | Integration-time register (0x01) |
| wtime_o | output | 8 | Wait-time register (0x03) |
| thr_low_o | output | 16 | Low threshold (0x05:0x04) |
| thr_high_o | output | 16 | High threshold (0x07:0x06) |
| pers_o | output | 8 | Persistence register (0x0C) |
| cfg_o | output | 8 | Configuration register (0x0D) |
| ctl_o | output | 8 | Gain control register (0x0F) |

## Verification
A byte or request sampled at clock edge k has its effect due at fixed points:

- A write strobe and a read byte appear in the cycle after edge k.
- The updated register output appears after edge k+1.
- An interrupt-clear pulse appears in the cycle after edge k+1.

Each bench task drives its inputs on a falling edge, which is then sampled at the next rising edge k. It reads the strobe and the read byte at the falling edge after k, and reads the clear pulse and the register outputs at the falling edge after k+1. Each task leaves a third idle cycle before the next event, so the machine is back in `S_IDLE` when that event arrives.

// File: rtl/cab_pkg.sv
package cab_pkg;

    localparam int DW = 8;
    localparam int AW = 5;
    localparam int NSLOT = 10;
    localparam int SW = $clog2(NSLOT + 1);
    localparam logic [SW-1:0] NO_SLOT = SW'(NSLOT);

    localparam logic [1:0] TY_SAME = 2'b00;
    localparam logic [1:0] TY_INCR = 2'b01;
    localparam logic [1:0] TY_RSVD = 2'b10;
    localparam logic [1:0] TY_SPEC = 2'b11;

    localparam logic [AW-1:0] SF_CLEAR = 5'b00110;

    localparam logic [AW-1:0] A_ID     = 5'h12;
    localparam logic [AW-1:0] A_STATUS = 5'h13;
    localparam logic [AW-1:0] A_C0LO   = 5'h14;
    localparam logic [AW-1:0] A_C0HI   = 5'h15;
    localparam logic [AW-1:0] A_C1LO   = 5'h16;
    localparam logic [AW-1:0] A_C1HI   = 5'h17;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_WRITE,
        S_READ,
        S_CLEAR
    } cab_state_t;

    // Map a register address onto a storage slot; NO_SLOT for anything not writable.
    function automatic logic [SW-1:0] slot_of(input logic [AW-1:0] a);
        case (a)
            5'h00:   slot_of = SW'(0);
            5'h01:   slot_of = SW'(1);
            5'h03:   slot_of = SW'(2);
            5'h04:   slot_of = SW'(3);
            5'h05:   slot_of = SW'(4);
            5'h06:   slot_of = SW'(5);
            5'h07:   slot_of = SW'(6);
            5'h0C:   slot_of = SW'(7);
            5'h0D:   slot_of = SW'(8);
            5'h0F:   slot_of = SW'(9);
            default: slot_of = NO_SLOT;
        endcase
    endfunction

    // Both timing registers come up at their shortest setting.
    function automatic logic [DW-1:0] slot_reset(input int s);
        slot_reset = (s == 1 || s == 2) ? 8'hFF : 8'h00;
    endfunction

endpackage

// File: rtl/cab_fsm.sv
module cab_fsm
    import cab_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_first,
    input  logic [DW-1:0] rx_data,
    input  logic          rd_req,
    output logic          wr_fire,
    output logic          rd_fire,
    output logic          clr_fire,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] byte_q
);

    cab_state_t state, nxt;
    logic       auto_q;

    logic [1:0]    cmd_ty;
    logic [AW-1:0] cmd_fld;
    assign cmd_ty  = byte_q[6:5];
    assign cmd_fld = byte_q[AW-1:0];

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (rx_valid) begin
                    if (rx_first && rx_data[7]) nxt = S_DECODE;
                    else                        nxt = S_WRITE;
                end else if (rd_req) begin
                    nxt = S_READ;
                end
            end
            S_DECODE: nxt = (cmd_ty == TY_SPEC && cmd_fld == SF_CLEAR) ? S_CLEAR : S_IDLE;
            S_WRITE:  nxt = S_IDLE;
            S_READ:   nxt = S_IDLE;
            S_CLEAR:  nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        byte_q <= '0;
        else if (state == S_IDLE && rx_valid) byte_q <= rx_data;
    end

    // Held address and mode: loaded by same/incr commands, stepped after data bytes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            auto_q   <= 1'b0;
        end else if (state == S_DECODE && (cmd_ty == TY_SAME || cmd_ty == TY_INCR)) begin
            cur_addr <= cmd_fld;
            auto_q   <= (cmd_ty == TY_INCR);
        end else if ((state == S_WRITE || state == S_READ) && auto_q) begin
            cur_addr <= cur_addr + AW'(1);
        end
    end

    always_comb begin
        wr_fire  = 1'b0;
        rd_fire  = 1'b0;
        clr_fire = 1'b0;
        unique case (state)
            S_WRITE: wr_fire  = 1'b1;
            S_READ:  rd_fire  = 1'b1;
            S_CLEAR: clr_fire = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cab_regbank.sv
module cab_regbank
    import cab_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_fire,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    output logic                    wr_ok,
    output logic [NSLOT-1:0][DW-1:0] regs
);

    logic [SW-1:0] slot;
    assign slot  = slot_of(addr);
    assign wr_ok = wr_fire && (slot != NO_SLOT);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          regs[s] <= slot_reset(s);
            else if (wr_ok && slot == SW'(s))    regs[s] <= wdata;
        end
    end

endmodule

// File: rtl/cab_readmux.sv
module cab_readmux
    import cab_pkg::*;
#(
    parameter logic [DW-1:0] ID_VALUE = 8'h3C
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_fire,
    input  logic [AW-1:0]            addr,
    input  logic [NSLOT-1:0][DW-1:0] regs,
    input  logic [DW-1:0]            status_in,
    input  logic [1:0][2*DW-1:0]     chan,
    output logic                     rd_valid,
    output logic [DW-1:0]            rd_data
);

    logic [1:0][DW-1:0] shadow;
    logic [1:0][AW-1:0] lo_addr;
    assign lo_addr[0] = A_C0LO;
    assign lo_addr[1] = A_C1LO;

    for (genvar c = 0; c < 2; c++) begin : g_shadow
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           shadow[c] <= '0;
            else if (rd_fire && addr == lo_addr[c]) shadow[c] <= chan[c][2*DW-1:DW];
        end
    end

    logic [SW-1:0] slot;
    logic [DW-1:0] sel;
    assign slot = slot_of(addr);

    always_comb begin
        if (slot != NO_SLOT) begin
            sel = regs[slot];
        end else begin
            case (addr)
                A_ID:     sel = ID_VALUE;
                A_STATUS: sel = status_in;
                A_C0LO:   sel = chan[0][DW-1:0];
                A_C0HI:   sel = shadow[0];
                A_C1LO:   sel = chan[1][DW-1:0];
                A_C1HI:   sel = shadow[1];
                default:  sel = '0;
            endcase
        end
    end

    assign rd_valid = rd_fire;
    assign rd_data  = rd_fire ? sel : '0;

endmodule

// File: rtl/cmd_reg_access.sv
module cmd_reg_access
    import cab_pkg::*;
#(
    parameter logic [7:0] ID_VALUE = 8'h3C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_first,
    input  logic [7:0]  rx_data,
    input  logic        rd_req,
    input  logic [15:0] ch0_data,
    input  logic [15:0] ch1_data,
    input  logic [7:0]  status_in,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        wr_stb,
    output logic [4:0]  wr_addr,
    output logic [7:0]  wr_data,
    output logic        int_clr,
    output logic [7:0]  en_o,
    output logic [7:0]  atime_o,
    output logic [7:0]  wtime_o,
    output logic [15:0] thr_low_o,
    output logic [15:0] thr_high_o,
    output logic [7:0]  pers_o,
    output logic [7:0]  cfg_o,
    output logic [7:0]  ctl_o
);

    logic                     wr_fire, rd_fire, clr_fire;
    logic [AW-1:0]            cur_addr;
    logic [DW-1:0]            byte_q;
    logic [NSLOT-1:0][DW-1:0] regs;
    logic [1:0][2*DW-1:0]     chan;

    assign chan[0] = ch0_data;
    assign chan[1] = ch1_data;

    cab_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_first (rx_first),
        .rx_data  (rx_data),
        .rd_req   (rd_req),
        .wr_fire  (wr_fire),
        .rd_fire  (rd_fire),
        .clr_fire (clr_fire),
        .cur_addr (cur_addr),
        .byte_q   (byte_q)
    );

    cab_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .addr    (cur_addr),
        .wdata   (byte_q),
        .wr_ok   (wr_stb),
        .regs    (regs)
    );

    cab_readmux #(.ID_VALUE(ID_VALUE)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_fire   (rd_fire),
        .addr      (cur_addr),
        .regs      (regs),
        .status_in (status_in),
        .chan      (chan),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign wr_addr    = cur_addr;
    assign wr_data    = byte_q;
    assign int_clr    = clr_fire;
    assign en_o       = regs[0];
    assign atime_o    = regs[1];
    assign wtime_o    = regs[2];
    assign thr_low_o  = {regs[4], regs[3]};
    assign thr_high_o = {regs[6], regs[5]};
    assign pers_o     = regs[7];
    assign cfg_o      = regs[8];
    assign ctl_o      = regs[9];

endmodule

// File: rtl/cmd_reg_access_chk.sv
module cmd_reg_access_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        rx_first,
    input logic [7:0]  rx_data,
    input logic        rd_req,
    input logic        rd_valid,
    input logic [7:0]  rd_data,
    input logic        wr_stb,
    input logic [4:0]  wr_addr,
    input logic [7:0]  wr_data,
    input logic        int_clr,
    input logic [7:0]  atime_o,
    input logic [7:0]  ctl_o
);

    // R4: the clear pulse lasts one cycle
    assert_clr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_clr |=> !int_clr);

    // R4: a clear pulse is caused by the clear command two cycles earlier
    assert_clr_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_clr |-> $past(rx_valid && rx_first && rx_data == 8'hE6, 2));

    // R9: a write strobe follows a received byte by one cycle
    assert_wr_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(rx_valid));

    // R9: the written value reaches the register output next cycle
    assert_atime_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == 5'h01) |=> (atime_o == $past(wr_data)));

    assert_ctl_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == 5'h0F) |=> (ctl_o == $past(wr_data)));

    // R6: read data follows a request by one cycle
    assert_rd_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    // R6: actions never overlap
    assert_one_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, wr_stb, int_clr}));

    // R6: idle read data is zero
    assert_rd_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == 8'h00);

endmodule

bind cmd_reg_access cmd_reg_access_chk u_chk (.*);

// File: tb/sim_cmd_reg_access.sv
`timescale 1ns/1ps
module sim_cmd_reg_access;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_first = 1'b0, rd_req = 1'b0;
    logic [7:0]  rx_data = 8'h00, status_in = 8'h11;
    logic [15:0] ch0_data = 16'h0000, ch1_data = 16'h0000;
    logic        rd_valid, wr_stb, int_clr;
    logic [7:0]  rd_data, wr_data, en_o, atime_o, wtime_o, pers_o, cfg_o, ctl_o;
    logic [4:0]  wr_addr;
    logic [15:0] thr_low_o, thr_high_o;

    int n_run = 0, n_fail = 0;
    logic       o_stb, o_clr;
    logic [4:0] o_addr;
    logic [7:0] o_data, o_rd;
    logic       o_rv;

    always #2 clk = ~clk;

    cmd_reg_access u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic first, input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_first = first; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_first = 1'b0;
        o_stb = wr_stb; o_addr = wr_addr; o_data = wr_data; o_clr = int_clr;
        @(negedge clk);
        o_clr = o_clr | int_clr;
    endtask

    task automatic rd();
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        o_rv = rd_valid; o_rd = rd_data;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 atime", atime_o, 8'hFF);
        chk("R1 wtime", wtime_o, 8'hFF);
        chk("R1 others", {en_o, pers_o, cfg_o, ctl_o, thr_low_o, thr_high_o}, 64'h0);
        rd();
        chk("R6 read valid", o_rv, 1);
        chk("R1 R6 default addr 0", o_rd, 8'h00);
        rd();
        chk("R1 same-address mode after reset", o_rd, 8'h00);
    endtask

    task automatic t_same();
        send(1, 8'h81);
        chk("R2 command no strobe", o_stb, 0);
        send(0, 8'h12);
        chk("R9 strobe", o_stb, 1);
        chk("R9 addr", o_addr, 5'h01);
        chk("R9 data", o_data, 8'h12);
        chk("R9 reg updated", atime_o, 8'h12);
        send(0, 8'h34);
        chk("R2 same addr again", o_addr, 5'h01);
        chk("R2 atime value", atime_o, 8'h34);
        rd();
        chk("R2 R6 read held addr", o_rd, 8'h34);
    endtask

    task automatic t_incr();
        send(1, 8'hA4);
        send(0, 8'h11); send(0, 8'h22); send(0, 8'h33); send(0, 8'h44);
        chk("R3 R10 low threshold", thr_low_o, 16'h2211);
        chk("R3 R10 high threshold", thr_high_o, 16'h4433);
        send(1, 8'hA4);
        for (int i = 0; i < 4; i++) begin
            rd();
            chk("R3 auto read", o_rd, 8'(8'h11 * (i + 1)));
        end
    endtask

    task automatic t_wrap();
        send(1, 8'hBF);
        send(0, 8'h55);
        chk("R8 unmapped write no strobe", o_stb, 0);
        send(0, 8'h66);
        chk("R3 wrap to 0", o_addr, 5'h00);
        chk("R3 wrap value", en_o, 8'h66);
    endtask

    task automatic t_special();
        send(1, 8'h8D);
        send(1, 8'hE6);
        chk("R4 clear pulse", o_clr, 1);
        send(1, 8'hE0);
        chk("R4 no-op code", o_clr, 0);
        send(1, 8'hE3);
        chk("R4 other code", o_clr, 0);
        send(1, 8'hC2);
        chk("R4 reserved type", o_clr, 0);
        send(0, 8'h9A);
        chk("R4 R5 addr kept", o_addr, 5'h0D);
        chk("R5 non-first MSB set is data", cfg_o, 8'h9A);
        send(1, 8'h05);
        chk("R5 first byte MSB clear is data", o_stb, 1);
        chk("R5 value", cfg_o, 8'h05);
    endtask

    task automatic t_shadow();
        ch0_data = 16'h1234; ch1_data = 16'h5678;
        send(1, 8'hB4);
        rd(); chk("R7 ch0 low", o_rd, 8'h34);
        ch0_data = 16'hABCD;
        rd(); chk("R7 ch0 shadow high", o_rd, 8'h12);
        rd(); chk("R7 ch1 low", o_rd, 8'h78);
        ch1_data = 16'h9999;
        rd(); chk("R7 ch1 shadow high", o_rd, 8'h56);
    endtask

    task automatic t_readonly();
        send(1, 8'h92);
        send(0, 8'h77);
        chk("R8 read-only no strobe", o_stb, 0);
        rd(); chk("R10 R8 id unchanged", o_rd, 8'h3C);
        send(1, 8'h93);
        rd(); chk("R10 status", o_rd, 8'h11);
        send(1, 8'h82);
        send(0, 8'h44);
        chk("R8 unmapped write", o_stb, 0);
        rd(); chk("R8 unmapped read zero", o_rd, 8'h00);
        chk("R8 state untouched", {en_o, atime_o}, 16'h6634);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_same();
        t_incr();
        t_wrap();
        t_special();
        t_shadow();
        t_readonly();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule